// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation structure held in memory. A requester presents the virtual address together with the frame number of the top-level directory. The walker splits the address into a 10-bit directory index, a 10-bit table index and a 12-bit byte offset, which gives 4 KB pages. It fetches the directory entry, then the second-level entry, and finishes with either a physical address or a page fault.

Memory is reached through a word-addressed read port. The walker holds `mem_req_o` high with a steady word address until the memory returns `mem_rvalid_i` together with the data word. Each table holds 1K 32-bit entries, so one table fills exactly one 4 KB frame. Bit 0 of an entry is the presence flag. Bits 31:12 of an entry hold a frame number: for a directory entry that frame is the second-level table, and for a second-level entry it is the data page. Bits 11:1 carry status information that the walker does not use. The walker handles one translation at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it is released, `busy_o`, `done_o`, `fault_o` and `mem_req_o` are all 0.
- R2: The first read of a walk uses word address {`dir_frame_i`, vaddr[31:22]}, taken from the values presented when the request was accepted.
- R3: When the directory entry has bit 0 set, the second read uses word address {entry[31:12], vaddr[21:12]}.
- R4: When both entries have bit 0 set, `done_o` pulses for one cycle and `paddr_o` equals {second entry[31:12], vaddr[11:0]}. For example, 0x00402004 selects directory index 1, table index 2 and offset 4.
- R5: A directory entry with bit 0 clear raises `fault_o` after exactly one memory read, and no second-level read is issued.
- R6: A second-level entry with bit 0 clear raises `fault_o` after exactly two reads, and `done_o` stays low.
- R7: `busy_o` is 1 from the cycle after a request is accepted until the cycle in which the result pulse appears. A `req_valid_i` that arrives while `busy_o` is 1 is ignored: it starts no walk and produces no result.
- R8: `done_o` and `fault_o` are never 1 together, and each is 1 for one cycle per walk.
- R9: Entry bits 11:1 have no effect on the read addresses or on the physical address.
- R10: While `mem_req_o` is 1 and no `mem_rvalid_i` has arrived, `mem_addr_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request; taken only when idle |
| req_vaddr_i | input | 32 | Virtual address to translate |
| dir_frame_i | input | 20 | Frame number of the top-level directory |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| fault_o | output | 1 | One-cycle pulse: page fault |
| paddr_o | output | 32 | Physical address, updated when `done_o` pulses |
| mem_req_o | output | 1 | Read request, held high until data returns |
| mem_addr_o | output | 30 | Word address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |

## Verification
If the walk state is wrong, the damage is visible at the memory port on the first read: a bad word address, or a second read issued after a non-present directory entry. The bench logs every read and compares the log against its own model of the walk when the result pulse arrives. A stale captured frame or index shows up as a wrong second-read address or a wrong `paddr_o` in that same transaction. Memory latency varies from 0 to 3 cycles, so a walker that drops its request or changes its address too early shows a wrong value at the port within one walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned ENT_LOG2  = 2;   // 4-byte entries
  localparam int unsigned PRES_BIT  = 0;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_DIR  = 2'd1,
    WALK_PTE  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/pt_vaddr_split.sv
module pt_vaddr_split #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  localparam int unsigned TOP_W = VA_W - OFF_W - IDX_W
) (
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [TOP_W-1:0] top_idx_o,
  output logic [IDX_W-1:0] sub_idx_o,
  output logic [OFF_W-1:0] off_o
);
  assign top_idx_o = vaddr_i[VA_W-1 -: TOP_W];
  assign sub_idx_o = vaddr_i[OFF_W +: IDX_W];
  assign off_o     = vaddr_i[OFF_W-1:0];
endmodule

// File: rtl/pt_addr_form.sv
module pt_addr_form #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned IDX_W    = 10,
  localparam int unsigned TOP_W   = VA_W - OFF_W - IDX_W,
  localparam int unsigned FRAME_W = VA_W - OFF_W,
  localparam int unsigned WADDR_W = FRAME_W + IDX_W
) (
  input  logic               sel_pte_i,
  input  logic [FRAME_W-1:0] dir_frame_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic [TOP_W-1:0]   top_idx_i,
  input  logic [IDX_W-1:0]   sub_idx_i,
  input  logic [FRAME_W-1:0] page_frame_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic [VA_W-1:0]    paddr_o
);
  logic [IDX_W-1:0] top_ext;

  // directory index slot is as wide as a table index; pad a narrower one
  generate
    if (TOP_W < IDX_W) begin : g_pad
      assign top_ext = {{(IDX_W-TOP_W){1'b0}}, top_idx_i};
    end else begin : g_same
      assign top_ext = top_idx_i[IDX_W-1:0];
    end
  endgenerate

  assign mem_addr_o = sel_pte_i ? {tbl_frame_i, sub_idx_i} : {dir_frame_i, top_ext};
  assign paddr_o    = {page_frame_i, off_i};
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        mem_rvalid_i,
  input  logic        present_i,
  output logic        accept_o,
  output logic        take_pde_o,
  output logic        take_pte_o,
  output logic        sel_pte_o,
  output logic        busy_o,
  output logic        mem_req_o,
  output logic        done_o,
  output logic        fault_o
);
  walk_state_e state_q, state_d;
  logic        miss;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WALK_IDLE: if (req_valid_i)  state_d = WALK_DIR;
      WALK_DIR:  if (mem_rvalid_i) state_d = present_i ? WALK_PTE : WALK_IDLE;
      WALK_PTE:  if (mem_rvalid_i) state_d = WALK_IDLE;
      default:                     state_d = WALK_IDLE;
    endcase
  end

  assign accept_o   = (state_q == WALK_IDLE) && req_valid_i;
  assign take_pde_o = (state_q == WALK_DIR) && mem_rvalid_i && present_i;
  assign take_pte_o = (state_q == WALK_PTE) && mem_rvalid_i && present_i;
  assign miss       = (state_q != WALK_IDLE) && mem_rvalid_i && !present_i;
  assign sel_pte_o  = (state_q == WALK_PTE);
  assign busy_o     = (state_q != WALK_IDLE);
  assign mem_req_o  = (state_q == WALK_DIR) || (state_q == WALK_PTE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= take_pte_o;
      fault_o <= miss;
    end
  end

  assert_dir_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WALK_DIR && mem_rvalid_i && !present_i) |=> (fault_o && !mem_req_o));
  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> !busy_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W     = pt_walk_pkg::VA_W,
  parameter int unsigned OFF_W    = pt_walk_pkg::OFF_W,
  localparam int unsigned IDX_W   = OFF_W - ENT_LOG2,
  localparam int unsigned TOP_W   = VA_W - OFF_W - IDX_W,
  localparam int unsigned FRAME_W = VA_W - OFF_W,
  localparam int unsigned WADDR_W = VA_W - ENT_LOG2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [FRAME_W-1:0] dir_frame_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic [VA_W-1:0]    paddr_o,
  output logic               mem_req_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [VA_W-1:0]    mem_rdata_i
);
  logic [VA_W-1:0]    vaddr_q;
  logic [FRAME_W-1:0] dir_frame_q, tbl_frame_q;
  logic [TOP_W-1:0]   top_idx;
  logic [IDX_W-1:0]   sub_idx;
  logic [OFF_W-1:0]   off;
  logic [VA_W-1:0]    paddr_d;
  logic [FRAME_W-1:0] entry_frame;
  logic               entry_present;
  logic               accept, take_pde, take_pte, sel_pte;
  logic               unused_status;

  assign entry_frame   = mem_rdata_i[VA_W-1:OFF_W];
  assign entry_present = mem_rdata_i[PRES_BIT];
  assign unused_status = ^mem_rdata_i[OFF_W-1:PRES_BIT+1];

  pt_vaddr_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .vaddr_i   (vaddr_q),
    .top_idx_o (top_idx),
    .sub_idx_o (sub_idx),
    .off_o     (off)
  );

  pt_walk_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .mem_rvalid_i (mem_rvalid_i),
    .present_i    (entry_present),
    .accept_o     (accept),
    .take_pde_o   (take_pde),
    .take_pte_o   (take_pte),
    .sel_pte_o    (sel_pte),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .done_o       (done_o),
    .fault_o      (fault_o)
  );

  pt_addr_form #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_form (
    .sel_pte_i    (sel_pte),
    .dir_frame_i  (dir_frame_q),
    .tbl_frame_i  (tbl_frame_q),
    .top_idx_i    (top_idx),
    .sub_idx_i    (sub_idx),
    .page_frame_i (entry_frame),
    .off_i        (off),
    .mem_addr_o   (mem_addr_o),
    .paddr_o      (paddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q     <= '0;
      dir_frame_q <= '0;
      tbl_frame_q <= '0;
      paddr_o     <= '0;
    end else begin
      if (accept) begin
        vaddr_q     <= req_vaddr_i;
        dir_frame_q <= dir_frame_i;
      end
      if (take_pde) tbl_frame_q <= entry_frame;
      if (take_pte) paddr_o     <= paddr_d;
    end
  end

  assert_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> $stable(mem_addr_o));
  assert_req_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> $stable(vaddr_q));
  assert_offset_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] dir_frame = '0;
  logic        busy, done, fault, mem_req, mem_rvalid = 1'b0;
  logic [31:0] paddr, mem_rdata = '0;
  logic [29:0] mem_addr;

  always #5 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .dir_frame_i(dir_frame), .busy_o(busy), .done_o(done), .fault_o(fault),
    .paddr_o(paddr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  typedef struct packed {
    logic        flt;
    logic [31:0] pa;
    logic [1:0]  n;
    logic [29:0] a0;
    logic [29:0] a1;
  } exp_t;

  logic [31:0] mem_q [logic [29:0]];
  exp_t        exp_q [$];
  logic [29:0] rd_log [$];
  int          nchk = 0, nfail = 0, addr_moves = 0;
  bit          pulse_prev = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [29:0] a);
    return mem_q.exists(a) ? mem_q[a] : 32'h0;
  endfunction

  // memory responder with latency cycling 0..3
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req && rst_n) begin
        logic [29:0] a;
        a = mem_addr;
        rd_log.push_back(a);
        repeat (lat) begin
          @(negedge clk);
          if (mem_addr != a) addr_moves++;
        end
        mem_rdata  = rd(a);
        mem_rvalid = 1'b1;
        lat = (lat + 1) % 4;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (pulse_prev) begin
        chk(!done && !fault, "R8 pulse longer than one cycle", {30'b0, done, fault}, 32'h0);
        pulse_prev = 0;
      end else if (done || fault) begin
        pulse_prev = 1;
        chk(!(done && fault), "R8 done and fault together", {30'b0, done, fault}, 32'h0);
        if (exp_q.size() == 0) begin
          chk(0, "R7 result with no accepted request", {30'b0, done, fault}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(fault == e.flt, "R5/R6 fault indication", {31'b0, fault}, {31'b0, e.flt});
          if (!e.flt) chk(paddr == e.pa, "R4 physical address", paddr, e.pa);
          chk(rd_log.size() == int'(e.n), "R5 number of reads", rd_log.size(), {30'b0, e.n});
          if (rd_log.size() >= 1) chk(rd_log[0] == e.a0, "R2 directory read address", {2'b0, rd_log[0]}, {2'b0, e.a0});
          if (rd_log.size() >= 2 && e.n == 2) chk(rd_log[1] == e.a1, "R3 table read address", {2'b0, rd_log[1]}, {2'b0, e.a1});
          rd_log.delete();
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [19:0] df, input bit poke);
    exp_t e;
    logic [31:0] pde, pte;
    e = '0;
    e.a0 = {df, va[31:22]};
    pde  = rd(e.a0);
    if (!pde[0]) begin
      e.flt = 1'b1; e.n = 2'd1;
    end else begin
      e.a1 = {pde[31:12], va[21:12]};
      pte  = rd(e.a1);
      e.n  = 2'd2;
      e.flt = !pte[0];
      e.pa = {pte[31:12], va[11:0]};
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; dir_frame = df;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", {31'b0, busy}, 32'h1);
    if (poke) begin
      req_valid = 1'b1; req_vaddr = ~va; dir_frame = ~df;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 outputs in reset", {28'b0, busy, done, fault, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 outputs after reset", {28'b0, busy, done, fault, mem_req}, 32'h0);

    // table contents
    mem_q[{20'h00010, 10'd1}]     = 32'h0002_0001;
    mem_q[{20'h00020, 10'd2}]     = 32'h0ABC_D001;
    mem_q[{20'h00020, 10'd3}]     = 32'h1234_5FFE;
    mem_q[{20'h00010, 10'd5}]     = 32'h0004_0000;
    mem_q[{20'h00010, 10'h3FF}]   = 32'h0003_0FFF;
    mem_q[{20'h00030, 10'h3FF}]   = 32'hFFFF_FFFF;
    mem_q[{20'hFFFFF, 10'd0}]     = 32'h0005_0001;
    mem_q[{20'h00050, 10'd0}]     = 32'h0077_7001;
    mem_q[{20'h00050, 10'd1}]     = 32'h0088_8FFF;

    walk(32'h0040_2004, 20'h00010, 0);  // R4 worked example: 1/2/4
    walk(32'h0140_0123, 20'h00010, 0);  // R5 directory entry absent
    walk(32'h0040_3ABC, 20'h00010, 0);  // R6 table entry absent
    walk(32'hFFFF_F555, 20'h00010, 0);  // R9 status bits set in both entries
    walk(32'h0000_0FFF, 20'hFFFFF, 0);  // R2 directory at top frame
    walk(32'h0000_1000, 20'hFFFFF, 1);  // R7 request while busy ignored; R9
    walk(32'h0080_0000, 20'h00010, 1);  // R5 unmapped directory index, poke
    walk(32'h0040_2FFF, 20'h00010, 0);  // R4 max offset

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 missing results", exp_q.size(), 32'h0);
    chk(addr_moves == 0, "R10 address changed while waiting", addr_moves, 32'h0);
    chk(!busy && !mem_req, "R7 idle at end", {30'b0, busy, mem_req}, 32'h0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule